// File: doc/BRIEF.md
# Asynchronous Host Write Bridge

This block lets a microprocessor with a strobe-based, unclocked bus write into registers that live on an internal synchronous bus. The host presents a 20-bit address and 16-bit data. It then pulls chip select, address strobe and data strobe low, with the read/write line low. The bridge brings these controls into the internal clock domain and issues a single one-clock write strobe with the captured address and data. It then waits for the register side to report completion and answers the host on an active-low acknowledge line.

The acknowledge has three levels. It is high-impedance while chip select is inactive. It is driven high while the internal access is outstanding. It is driven low once the access is done, and it is driven high again as soon as the host lets go of either strobe. A static mode input picks this asynchronous mode when it is 0. When it is 1 the bridge ignores the host entirely.

Top module: `hostwr_bridge`

## Requirements
- R1: The acknowledge output enable `h_ack_oe` is 1 exactly while `h_cs_n` is 0 and `mode_sel` is 0, with no clock delay. While `h_cs_n` is 1 the acknowledge is high-impedance (`h_ack_oe` = 0).
- R2: After chip select falls, `h_ack_n` is driven 1 until the internal write has completed.
- R3: An internal write is launched only when chip select, address strobe and data strobe are all low and `h_rw` is 0 (0 = write, 1 = read). A cycle with `h_rw` = 1 produces no write and never drives the acknowledge low.
- R4: `h_ack_n` goes to 0 on the clock after `bus_done` is sampled at 1, provided both strobes are still seen asserted. It stays 0 while they remain asserted. If a strobe is released before completion, the acknowledge is never driven low for that cycle.
- R5: Each host cycle produces exactly one `bus_wr_en` pulse, one clock wide, however long the strobes stay low.
- R6: With `mode_sel` = 1 the host strobes are ignored: no internal write occurs and `h_ack_oe` stays 0.
- R7: After either strobe rises while the acknowledge is low, `h_ack_n` is still 0 after the first rising clock edge and is back to 1 after the second. This delay is the two-stage input synchronizer.
- R8: During the `bus_wr_en` cycle, `bus_addr` and `bus_wdata` equal the host address and data of that cycle.
- R9: A new host cycle is accepted only after both strobes have been seen deasserted together. Releasing and re-asserting one strobe while the other stays low starts no new write.
- R10: During and right after reset, `bus_wr_en` is 0 and `h_ack_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | Static mode: 0 selects the asynchronous host mode, 1 disables the bridge |
| h_addr | input | 20 | Host address, held stable for the whole cycle |
| h_wdata | input | 16 | Host write data, held stable for the whole cycle |
| h_cs_n | input | 1 | Host chip select, active low |
| h_as_n | input | 1 | Host address strobe, active low |
| h_ds_n | input | 1 | Host data strobe, active low |
| h_rw | input | 1 | Host direction: 1 read, 0 write |
| h_ack_n | output | 1 | Acknowledge value, active low |
| h_ack_oe | output | 1 | Acknowledge output enable; 0 means high-impedance |
| bus_wr_en | output | 1 | One-clock internal write strobe |
| bus_addr | output | 20 | Internal write address |
| bus_wdata | output | 16 | Internal write data |
| bus_done | input | 1 | Internal completion pulse from the register side |

## Verification
Two events can meet in the state machine at nearly the same time: the register side's completion and the host's release of a strobe. The bench makes them coincide by setting the completion responder to a two-clock delay and releasing the address strobe on the falling edge where the write pulse is first seen. That way the synchronized release reaches the state machine before completion moves it into its acknowledge state. The run is judged by watching the acknowledge stay driven high for the whole window. The scoreboard must still see one matched write, and the next ordinary write must complete normally.

// File: rtl/hostwr_pkg.sv
// Shared types for the asynchronous host write bridge.
// Assumes nothing beyond the state encoding fitting three bits.
package hostwr_pkg;

    // Control states of the bridge sequencer.
    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_WAIT_STROBES = 3'd1,
        ST_ISSUE        = 3'd2,
        ST_WAIT_DONE    = 3'd3,
        ST_ACK          = 3'd4,
        ST_WAIT_RELEASE = 3'd5
    } wr_state_t;

    // Bit positions of the host controls inside the synchronizer vector.
    localparam int CTL_CS  = 3;
    localparam int CTL_AS  = 2;
    localparam int CTL_DS  = 1;
    localparam int CTL_RW  = 0;
    localparam int CTL_W   = 4;

endpackage

// File: rtl/hostwr_sync.sv
// Multi-stage flip-flop synchronizer for a vector of unrelated level signals.
// Assumes each input level is held for longer than STAGES clock periods.
// Resets every stage to RESET_VAL (the inactive level of the inputs).
module hostwr_sync #(
    parameter int              WIDTH     = 4,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Stage 0 captures the raw input; each later stage copies the one before.
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= RESET_VAL;
                else        chain_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= RESET_VAL;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    // The last stage is the settled copy in the clock domain.
    assign dout = chain_q[LAST];

endmodule

// File: rtl/hostwr_capture.sv
// Holding register for the internal write address and data.
// Assumes the host keeps address and data stable for the whole cycle, so one
// load at the launch decision gives values valid for the write strobe.
module hostwr_capture #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);

    // Load address and data together when a write is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/hostwr_fsm.sv
// Sequencer of the host write bridge. It works on synchronized active-high
// versions of the host controls. It launches one internal write per host
// cycle, waits for completion, raises the acknowledge and then waits until
// both strobes are gone before it accepts another cycle.
// Assumes mode_sel is static during a host cycle.
module hostwr_fsm
    import hostwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic cs_act,
    input  logic as_act,
    input  logic ds_act,
    input  logic rd_lvl,
    input  logic bus_done,
    output logic launch,
    output logic bus_wr_en,
    output logic ack_low
);

    wr_state_t state_q, state_d;

    logic strobes_on;
    logic any_released;
    logic all_released;

    // Strobe summaries shared by several transitions.
    always_comb begin
        strobes_on   = cs_act && as_act && ds_act;
        any_released = !as_act || !ds_act;
        all_released = !as_act && !ds_act;
    end

    // Launch decision: a complete write request seen while waiting for strobes.
    always_comb begin
        launch = (state_q == ST_WAIT_STROBES) && strobes_on && !rd_lvl && !mode_sel;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!mode_sel && cs_act) state_d = ST_WAIT_STROBES;
            end
            ST_WAIT_STROBES: begin
                if (!cs_act || mode_sel)  state_d = ST_IDLE;
                else if (launch)          state_d = ST_ISSUE;
                else if (strobes_on)      state_d = ST_WAIT_RELEASE;
            end
            ST_ISSUE: begin
                state_d = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (bus_done) state_d = ST_ACK;
            end
            ST_ACK: begin
                if (any_released) state_d = ST_WAIT_RELEASE;
            end
            ST_WAIT_RELEASE: begin
                if (all_released) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs: a one-clock write strobe, and the acknowledge that drops as soon as a strobe goes.
    always_comb begin
        bus_wr_en = (state_q == ST_ISSUE);
        ack_low   = (state_q == ST_ACK) && as_act && ds_act;
    end

    // R5: a write strobe never lasts two clocks.
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en |=> !bus_wr_en);

    // R3: a write strobe follows a full write request seen one clock earlier.
    assert_write_needs_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en |-> $past(cs_act && as_act && ds_act && !rd_lvl));

    // R4: the acknowledge only starts after completion was sampled.
    assert_ack_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_low) |-> $past(bus_done));

    // R6: no write strobe comes out of the disabled mode.
    assert_mode_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en |-> !$past(mode_sel));

    // R9: while one strobe is still held after the acknowledge, no new write starts.
    assert_no_relaunch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RELEASE && (as_act || ds_act)) |=> !bus_wr_en);

endmodule

// File: rtl/hostwr_bridge.sv
// Top of the asynchronous host write bridge. It synchronizes the host
// controls and feeds them to the sequencer. It captures address and data
// for the internal bus and drives the acknowledge as a value and an enable.
// Assumes host address and data are stable while the strobes are low and
// that each strobe stays low for at least one clock period.
module hostwr_bridge
    import hostwr_pkg::*;
#(
    parameter int AW          = 20,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    input  logic          h_cs_n,
    input  logic          h_as_n,
    input  logic          h_ds_n,
    input  logic          h_rw,
    output logic          h_ack_n,
    output logic          h_ack_oe,
    output logic          bus_wr_en,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_done
);

    logic [CTL_W-1:0] ctl_raw;
    logic [CTL_W-1:0] ctl_sync;
    logic             launch;
    logic             ack_low;

    // Pack the raw host controls for the synchronizer.
    always_comb begin
        ctl_raw         = '1;
        ctl_raw[CTL_CS] = h_cs_n;
        ctl_raw[CTL_AS] = h_as_n;
        ctl_raw[CTL_DS] = h_ds_n;
        ctl_raw[CTL_RW] = h_rw;
    end

    hostwr_sync #(
        .WIDTH     (CTL_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({CTL_W{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ctl_raw),
        .dout  (ctl_sync)
    );

    hostwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .cs_act    (!ctl_sync[CTL_CS]),
        .as_act    (!ctl_sync[CTL_AS]),
        .ds_act    (!ctl_sync[CTL_DS]),
        .rd_lvl    (ctl_sync[CTL_RW]),
        .bus_done  (bus_done),
        .launch    (launch),
        .bus_wr_en (bus_wr_en),
        .ack_low   (ack_low)
    );

    hostwr_capture #(
        .AW (AW),
        .DW (DW)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .addr_in (h_addr),
        .data_in (h_wdata),
        .addr_q  (bus_addr),
        .data_q  (bus_wdata)
    );

    // Acknowledge pin: enabled straight from chip select, value from the sequencer.
    always_comb begin
        h_ack_oe = !h_cs_n && !mode_sel;
        h_ack_n  = !ack_low;
    end

    // R1: the acknowledge is never driven low while released to high-impedance.
    assert_ack_low_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_ack_n && !mode_sel) |-> !ctl_sync[CTL_CS]);

endmodule

// File: tb/sim_hostwr_bridge.sv
// Scoreboard bench for the host write bridge: host tasks push expected writes,
// a monitor pops them when the write strobe appears, a responder answers done.
module sim_hostwr_bridge;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_sel;
    logic [19:0] h_addr;
    logic [15:0] h_wdata;
    logic        h_cs_n, h_as_n, h_ds_n, h_rw;
    logic        h_ack_n, h_ack_oe;
    logic        bus_wr_en;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_done;

    int          n_checks = 0;
    int          n_fail   = 0;
    int          wr_count = 0;
    int          done_delay = 3;
    logic [35:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hostwr_bridge u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .h_addr(h_addr), .h_wdata(h_wdata),
        .h_cs_n(h_cs_n), .h_as_n(h_as_n), .h_ds_n(h_ds_n), .h_rw(h_rw),
        .h_ack_n(h_ack_n), .h_ack_oe(h_ack_oe),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_done(bus_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Monitor: each write strobe pops one expected item and compares it (R8).
    initial begin
        logic [35:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && bus_wr_en === 1'b1) begin
                wr_count++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "write with nothing expected", {bus_addr, bus_wdata}, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({bus_addr, bus_wdata} == e, "R8", "address/data",
                          {bus_addr, bus_wdata}, e);
                end
            end
        end
    end

    // Register-side responder: pulse done a set number of clocks after each write.
    initial begin
        bus_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && bus_wr_en === 1'b1) begin
                repeat (done_delay) @(negedge clk);
                bus_done = 1'b1;
                @(negedge clk);
                bus_done = 1'b0;
            end
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    // Full host write: acknowledge levels, one strobe, release timing.
    task automatic host_write(input logic [19:0] a, input logic [15:0] d,
                              input int hold, input bit rel_as);
        int start_cnt;
        @(negedge clk);
        h_addr = a; h_wdata = d; h_rw = 1'b0; h_cs_n = 1'b0;
        #1;
        check(h_ack_oe === 1'b1, "R1", "enable after chip select", h_ack_oe, 1);
        check(h_ack_n === 1'b1, "R2", "driven high at chip select", h_ack_n, 1);
        @(negedge clk);
        start_cnt = wr_count;
        exp_q.push_back({a, d});
        h_as_n = 1'b0; h_ds_n = 1'b0;
        @(posedge bus_done);
        check(h_ack_n === 1'b1, "R2", "high while pending", h_ack_n, 1);
        @(negedge clk);
        check(h_ack_n === 1'b0, "R4", "low after done", h_ack_n, 0);
        repeat (hold) @(negedge clk);
        check(h_ack_n === 1'b0 && h_ack_oe === 1'b1, "R4", "held low", h_ack_n, 0);
        check(wr_count - start_cnt == 1, "R5", "pulses while held", wr_count - start_cnt, 1);
        if (rel_as) h_as_n = 1'b1; else h_ds_n = 1'b1;
        @(negedge clk);
        check(h_ack_n === 1'b0, "R7", "low one edge after release", h_ack_n, 0);
        @(negedge clk);
        check(h_ack_n === 1'b1, "R7", "high two edges after release", h_ack_n, 1);
        h_as_n = 1'b1; h_ds_n = 1'b1; h_cs_n = 1'b1; h_rw = 1'b1;
        #1;
        check(h_ack_oe === 1'b0, "R1", "high-impedance after chip select", h_ack_oe, 0);
        repeat (5) @(negedge clk);
        check(wr_count - start_cnt == 1, "R5", "pulses per cycle", wr_count - start_cnt, 1);
    endtask

    initial begin
        int base;
        rst_n = 1'b0; mode_sel = 1'b0;
        h_addr = '0; h_wdata = '0;
        h_cs_n = 1'b1; h_as_n = 1'b1; h_ds_n = 1'b1; h_rw = 1'b1;
        repeat (3) @(negedge clk);
        check(bus_wr_en === 1'b0, "R10", "write strobe in reset", bus_wr_en, 0);
        check(h_ack_n === 1'b1, "R10", "ack value in reset", h_ack_n, 1);
        check(h_ack_oe === 1'b0, "R1", "enable with chip select high", h_ack_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_wr_en === 1'b0 && h_ack_n === 1'b1, "R10", "after reset", h_ack_n, 1);

        // Varied data patterns and completion delays.
        done_delay = 1; host_write(20'hFFFFF, 16'hFFFF, 0, 1'b1);
        done_delay = 5; host_write(20'h00000, 16'h0000, 3, 1'b0);
        done_delay = 3; host_write(20'hA5A5A, 16'h5A5A, 12, 1'b1);
        for (int i = 0; i < 4; i++) begin
            done_delay = 1 + i;
            host_write(20'h12345 + 20'(i * 20'h1111), 16'h8001 ^ 16'(i << 4), i, i[0]);
        end

        // R9: one strobe bounces while the other stays low; no new write.
        done_delay = 2;
        @(negedge clk);
        h_addr = 20'h0F0F0; h_wdata = 16'hBEEF; h_rw = 1'b0; h_cs_n = 1'b0;
        @(negedge clk);
        exp_q.push_back({20'h0F0F0, 16'hBEEF});
        h_as_n = 1'b0; h_ds_n = 1'b0;
        @(posedge bus_done);
        @(negedge clk);
        base = wr_count;
        h_as_n = 1'b1;
        repeat (4) @(negedge clk);
        h_as_n = 1'b0;
        repeat (8) @(negedge clk);
        check(wr_count == base, "R9", "no relaunch with one strobe held", wr_count - base, 0);
        check(h_ack_n === 1'b1, "R9", "ack stays high", h_ack_n, 1);
        h_as_n = 1'b1; h_ds_n = 1'b1; h_cs_n = 1'b1; h_rw = 1'b1;
        repeat (5) @(negedge clk);

        // R3: a read cycle launches nothing and never acknowledges low.
        base = wr_count;
        h_cs_n = 1'b0; h_rw = 1'b1;
        @(negedge clk);
        h_as_n = 1'b0; h_ds_n = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (h_ack_n !== 1'b1) check(1'b0, "R3", "ack low on read", h_ack_n, 1);
        end
        check(wr_count == base, "R3", "writes on read", wr_count - base, 0);
        h_as_n = 1'b1; h_ds_n = 1'b1; h_cs_n = 1'b1;
        repeat (5) @(negedge clk);

        // R6: disabled mode ignores a full write request.
        mode_sel = 1'b1;
        base = wr_count;
        h_cs_n = 1'b0; h_rw = 1'b0;
        #1;
        check(h_ack_oe === 1'b0, "R6", "enable in disabled mode", h_ack_oe, 0);
        @(negedge clk);
        h_as_n = 1'b0; h_ds_n = 1'b0;
        repeat (10) @(negedge clk);
        check(wr_count == base && h_ack_oe === 1'b0, "R6", "writes in disabled mode",
              wr_count - base, 0);
        h_as_n = 1'b1; h_ds_n = 1'b1; h_cs_n = 1'b1; h_rw = 1'b1;
        repeat (4) @(negedge clk);
        mode_sel = 1'b0;
        repeat (2) @(negedge clk);

        // R4: strobe release meets completion; acknowledge never goes low.
        done_delay = 2;
        base = wr_count;
        h_addr = 20'h3C3C3; h_wdata = 16'h1234; h_rw = 1'b0; h_cs_n = 1'b0;
        @(negedge clk);
        exp_q.push_back({20'h3C3C3, 16'h1234});
        h_as_n = 1'b0; h_ds_n = 1'b0;
        @(posedge bus_wr_en);
        @(negedge clk);
        h_as_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (h_ack_n !== 1'b1) check(1'b0, "R4", "ack low after early release", h_ack_n, 1);
        end
        check(wr_count - base == 1 && h_ack_n === 1'b1, "R4", "early release outcome",
              wr_count - base, 1);
        h_ds_n = 1'b1; h_cs_n = 1'b1; h_rw = 1'b1;
        repeat (5) @(negedge clk);

        // Recovery: an ordinary write still completes.
        done_delay = 2; host_write(20'h54321, 16'hC0DE, 2, 1'b0);
        check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule